// File: doc/BRIEF.md
# RV32 Integer ALU with Shifts

This block is the combinational arithmetic and logic unit of a small 32-bit RISC-V integer core. It takes two operands and a 4-bit operation code and returns one result word in the same cycle. Every candidate result is built in parallel: sum, difference, shifted word, the two compares and the three bitwise functions. A single multiplexer, driven by the operation code, then picks one.

The operation code is the instruction's funct3 field, with one extra bit placed above it. That top bit selects the alternate form of an operation: subtract instead of add, or arithmetic instead of logical right shift. The decoder drives code zero for plain addition, and memory address generation relies on that code. Shifts take their distance from the low five bits of the second operand only.

Top module: `rv_alu`

## Requirements
- R1: With op_sel = 4'b0000 the result is opd_a + opd_b, modulo 2^32.
- R2: With op_sel = 4'b1000 (alternate bit 3 set, funct3 = 000) the result is opd_a - opd_b, modulo 2^32.
- R3: For every shift code only opd_b[4:0] sets the shift distance; opd_b[31:5] has no effect on the result.
- R4: With op_sel = 4'b0001 the result is opd_a shifted left, with zeros filled in from the right.
- R5: With funct3 = 101, op_sel = 4'b0101 shifts opd_a right logically (zero fill) and op_sel = 4'b1101 shifts it right arithmetically (copies of opd_a[31] fill in).
- R6: With op_sel = 4'b0010 the result is 32'd1 when opd_a < opd_b as two's-complement numbers, else 32'd0.
- R7: With op_sel = 4'b0011 the result is 32'd1 when opd_a < opd_b as unsigned numbers, else 32'd0.
- R8: op_sel = 4'b0100 gives opd_a XOR opd_b, 4'b0110 gives OR and 4'b0111 gives AND.
- R9: The codes 4'b1001, 4'b1010, 4'b1011, 4'b1100, 4'b1110 and 4'b1111 give opd_a + opd_b.
- R10: The result depends only on the present inputs; it holds no state and follows a change of inputs without waiting for a clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opd_a | input | 32 | First operand; the value shifted by shift codes |
| opd_b | input | 32 | Second operand; its bits [4:0] give the shift distance |
| op_sel | input | 4 | Operation code: bit 3 selects the alternate form, bits [2:0] are funct3 |
| result | output | 32 | Selected result |

## Verification
The compare codes are tested right at the sign boundary. A signed compare built from the raw difference bit gives the wrong answer when the subtraction overflows, for example 0x80000000 against 0x7FFFFFFF. An unsigned compare wired with an inverted borrow flips every answer. The shift tests use distances of 0 and 31, and set junk in opd_b[31:5]. A shifter that reads the whole opd_b then clears the word, and one with a wrong fill bit leaks sign copies into a logical shift or zeros into an arithmetic one. Every unused code is also tried. A decoder that lets the alternate bit leak into other funct3 values returns a shift or compare where the sum belongs.

// File: rtl/rv_alu_pkg.sv
package rv_alu_pkg;

  // Width of the operation code: alternate bit above a 3-bit function field.
  localparam int OP_W = 4;
  localparam int F3_W = 3;

  // Function field values; the encoding is fixed by the instruction set.
  typedef enum logic [F3_W-1:0] {
    F3_ADDSUB = 3'b000,
    F3_SLL    = 3'b001,
    F3_SLT    = 3'b010,
    F3_SLTU   = 3'b011,
    F3_XOR    = 3'b100,
    F3_SR     = 3'b101,
    F3_OR     = 3'b110,
    F3_AND    = 3'b111
  } funct3_e;

endpackage

// File: rtl/rv_alu_addsub.sv
module rv_alu_addsub #(
  parameter int XLEN = 32
) (
  input  logic [XLEN-1:0] in_a,
  input  logic [XLEN-1:0] in_b,
  output logic [XLEN-1:0] sum,
  output logic [XLEN-1:0] diff,
  output logic            lt_signed,
  output logic            lt_unsigned
);

  localparam int MSB = XLEN - 1;

  logic [XLEN:0] sub_wide;

  // Sum for add and address generation.
  assign sum = in_a + in_b;

  // Difference as a + ~b + 1; the carry out is the inverse of the borrow.
  assign sub_wide = {1'b0, in_a} + {1'b0, ~in_b} + {{XLEN{1'b0}}, 1'b1};
  assign diff     = sub_wide[MSB:0];

  // Unsigned less-than: a borrow happened (no carry out).
  assign lt_unsigned = ~sub_wide[XLEN];

  // Signed less-than: signs differ -> a is less iff a is negative,
  // signs equal -> no overflow possible, the difference sign decides.
  always_comb begin
    if (in_a[MSB] != in_b[MSB]) begin
      lt_signed = in_a[MSB];
    end else begin
      lt_signed = sub_wide[MSB];
    end
  end

endmodule

// File: rtl/rv_alu_shifter.sv
module rv_alu_shifter #(
  parameter int XLEN = 32,
  parameter int SHW  = $clog2(XLEN)
) (
  input  logic [XLEN-1:0] data_in,
  input  logic [SHW-1:0]  shamt,
  input  logic            go_left,
  input  logic            arith,
  output logic [XLEN-1:0] data_out
);

  localparam int MSB = XLEN - 1;

  logic [XLEN-1:0] rev_in;
  logic [XLEN-1:0] stage [SHW+1];
  logic [XLEN-1:0] rev_out;
  logic            fill;

  // A left shift is a right shift of the bit-reversed word.
  for (genvar i = 0; i < XLEN; i++) begin : g_rev_in
    assign rev_in[i] = data_in[MSB-i];
  end

  assign stage[0] = go_left ? rev_in : data_in;

  // Sign copies enter only for an arithmetic right shift.
  assign fill = arith & ~go_left & data_in[MSB];

  // Log-depth barrel: stage k moves by 2**k when shamt[k] is set.
  for (genvar k = 0; k < SHW; k++) begin : g_stage
    localparam int DIST = 1 << k;
    assign stage[k+1] = shamt[k]
                      ? {{DIST{fill}}, stage[k][MSB:DIST]}
                      : stage[k];
  end

  for (genvar i = 0; i < XLEN; i++) begin : g_rev_out
    assign rev_out[i] = stage[SHW][MSB-i];
  end

  assign data_out = go_left ? rev_out : stage[SHW];

endmodule

// File: rtl/rv_alu_logic.sv
module rv_alu_logic #(
  parameter int XLEN = 32
) (
  input  logic [XLEN-1:0] in_a,
  input  logic [XLEN-1:0] in_b,
  output logic [XLEN-1:0] x_out,
  output logic [XLEN-1:0] o_out,
  output logic [XLEN-1:0] n_out
);

  assign x_out = in_a ^ in_b;
  assign o_out = in_a | in_b;
  assign n_out = in_a & in_b;

endmodule

// File: rtl/rv_alu.sv
module rv_alu
  import rv_alu_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic [XLEN-1:0] opd_a,
  input  logic [XLEN-1:0] opd_b,
  input  logic [OP_W-1:0] op_sel,
  output logic [XLEN-1:0] result
);

  localparam int SHW = $clog2(XLEN);

  logic            alt;
  funct3_e         f3;
  logic [XLEN-1:0] sum_w, diff_w, sh_w, xor_w, or_w, and_w;
  logic            lt_s, lt_u;
  logic            sh_left;
  logic [XLEN-1:0] lt_s_word, lt_u_word;

  assign alt = op_sel[OP_W-1];
  assign f3  = funct3_e'(op_sel[F3_W-1:0]);

  assign sh_left = (f3 == F3_SLL);

  rv_alu_addsub #(.XLEN(XLEN)) u_addsub (
    .in_a        (opd_a),
    .in_b        (opd_b),
    .sum         (sum_w),
    .diff        (diff_w),
    .lt_signed   (lt_s),
    .lt_unsigned (lt_u)
  );

  rv_alu_shifter #(.XLEN(XLEN), .SHW(SHW)) u_shift (
    .data_in  (opd_a),
    .shamt    (opd_b[SHW-1:0]),
    .go_left  (sh_left),
    .arith    (alt),
    .data_out (sh_w)
  );

  rv_alu_logic #(.XLEN(XLEN)) u_logic (
    .in_a  (opd_a),
    .in_b  (opd_b),
    .x_out (xor_w),
    .o_out (or_w),
    .n_out (and_w)
  );

  assign lt_s_word = {{(XLEN-1){1'b0}}, lt_s};
  assign lt_u_word = {{(XLEN-1){1'b0}}, lt_u};

  // Result multiplexer; the alternate bit is honoured only for
  // add/sub and right shift, every other alternate code falls back to add.
  always_comb begin
    result = sum_w;
    case (f3)
      F3_ADDSUB: result = alt ? diff_w : sum_w;
      F3_SLL:    result = alt ? sum_w  : sh_w;
      F3_SLT:    result = alt ? sum_w  : lt_s_word;
      F3_SLTU:   result = alt ? sum_w  : lt_u_word;
      F3_XOR:    result = alt ? sum_w  : xor_w;
      F3_SR:     result = sh_w;
      F3_OR:     result = alt ? sum_w  : or_w;
      F3_AND:    result = alt ? sum_w  : and_w;
      default:   result = sum_w;
    endcase
  end

endmodule

// File: rtl/rv_alu_chk.sv
module rv_alu_chk #(
  parameter int XLEN = 32
) (
  input logic [XLEN-1:0] opd_a,
  input logic [XLEN-1:0] opd_b,
  input logic [3:0]      op_sel,
  input logic [XLEN-1:0] result
);

  localparam int SHW = $clog2(XLEN);

  logic [SHW-1:0] sh_amt;
  assign sh_amt = opd_b[SHW-1:0];

  always_comb begin
    if (op_sel == 4'b0000) begin
      p_add_r1: assert (result == opd_a + opd_b);
    end
    if (op_sel == 4'b1000) begin
      p_sub_r2: assert (result == opd_a - opd_b);
    end
    if (op_sel == 4'b0001) begin
      p_sll_r4: assert (result == (opd_a << sh_amt));
    end
    if (op_sel == 4'b0101) begin
      p_srl_r5: assert (result == (opd_a >> sh_amt));
    end
    if (op_sel == 4'b1101) begin
      p_sra_r5: assert (result == XLEN'($signed(opd_a) >>> sh_amt));
    end
    if (op_sel == 4'b0010) begin
      p_slt_bool_r6: assert (result[XLEN-1:1] == '0);
    end
    if (op_sel == 4'b0011) begin
      p_sltu_val_r7: assert (result == {{(XLEN-1){1'b0}}, (opd_a < opd_b)});
    end
    if (op_sel == 4'b0100) begin
      p_xor_r8: assert (result == (opd_a ^ opd_b));
    end
    if (op_sel == 4'b1100 || op_sel == 4'b1111) begin
      p_undef_add_r9: assert (result == opd_a + opd_b);
    end
  end

endmodule

bind rv_alu rv_alu_chk #(.XLEN(XLEN)) u_chk (
  .opd_a  (opd_a),
  .opd_b  (opd_b),
  .op_sel (op_sel),
  .result (result)
);

// File: tb/sim_rv_alu.sv
module sim_rv_alu;

  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 100000;

  logic        clk;
  logic        rst_n;
  logic [31:0] opd_a, opd_b;
  logic [3:0]  op_sel;
  logic [31:0] result;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 0;

  typedef struct {
    logic [31:0] exp;
    string       tag;
  } item_t;

  item_t sb_q[$];

  rv_alu u0 (
    .opd_a  (opd_a),
    .opd_b  (opd_b),
    .op_sel (op_sel),
    .result (result)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  // Reference model written from the requirements.
  function automatic logic [31:0] model(input logic [31:0] a, input logic [31:0] b,
                                        input logic [3:0] op);
    logic [4:0] sh;
    sh = b[4:0];
    case (op)
      4'b0000: return a + b;
      4'b1000: return a - b;
      4'b0001: return a << sh;
      4'b0010: return ($signed(a) < $signed(b)) ? 32'd1 : 32'd0;
      4'b0011: return (a < b) ? 32'd1 : 32'd0;
      4'b0100: return a ^ b;
      4'b0101: return a >> sh;
      4'b1101: return 32'($signed(a) >>> sh);
      4'b0110: return a | b;
      4'b0111: return a & b;
      default: return a + b;
    endcase
  endfunction

  function automatic string tag_of(input logic [3:0] op);
    case (op)
      4'b0000: return "R1";
      4'b1000: return "R2";
      4'b0001: return "R4";
      4'b0101, 4'b1101: return "R5";
      4'b0010: return "R6";
      4'b0011: return "R7";
      4'b0100, 4'b0110, 4'b0111: return "R8";
      default: return "R9";
    endcase
  endfunction

  // Driver: apply one vector and queue its expected result.
  task automatic drive(input logic [31:0] a, input logic [31:0] b,
                       input logic [3:0] op, input string tag);
    item_t it;
    @(posedge clk);
    opd_a  <= a;
    opd_b  <= b;
    op_sel <= op;
    it.exp = model(a, b, op);
    it.tag = (tag == "") ? tag_of(op) : tag;
    sb_q.push_back(it);
  endtask

  // Monitor: compare at the falling edge, away from the driving edge.
  always @(negedge clk) begin
    if (sb_q.size() > 0) begin
      item_t it;
      it = sb_q.pop_front();
      n_checks++;
      if (result !== it.exp) begin
        n_fail++;
        $display("FAIL %s op=%b a=%h b=%h actual=%h expected=%h",
                 it.tag, op_sel, opd_a, opd_b, result, it.exp);
      end
    end
  end

  // Watchdog.
  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] s;
    rst_n  = 1'b0;
    opd_a  = '0;
    opd_b  = '0;
    op_sel = '0;
    repeat (2) @(posedge clk);
    rst_n = 1'b1;

    // Idle state: zero inputs give a zero sum (R1).
    drive(32'h0, 32'h0, 4'b0000, "R1");

    // R1 add, including wrap-around.
    drive(32'h0000_0005, 32'h0000_0007, 4'b0000, "R1");
    drive(32'hFFFF_FFFF, 32'h0000_0001, 4'b0000, "R1");
    // R2 subtract, including wrap.
    drive(32'h0000_0003, 32'h0000_0005, 4'b1000, "R2");
    drive(32'h8000_0000, 32'h0000_0001, 4'b1000, "R2");
    // R4 left shift, distance 0 and 31.
    drive(32'h8000_0001, 32'h0000_0000, 4'b0001, "R4");
    drive(32'h0000_0003, 32'h0000_001F, 4'b0001, "R4");
    // R5 logical vs arithmetic right shift of a negative word.
    drive(32'hF000_0000, 32'h0000_0004, 4'b0101, "R5");
    drive(32'hF000_0000, 32'h0000_0004, 4'b1101, "R5");
    drive(32'h8000_0000, 32'h0000_001F, 4'b1101, "R5");
    drive(32'h7000_0000, 32'h0000_001F, 4'b1101, "R5");
    // R3 junk in upper shift bits has no effect.
    drive(32'h1234_5678, 32'hFFFF_FFE4, 4'b0001, "R3");
    drive(32'h8765_4321, 32'hABCD_0008, 4'b0101, "R3");
    drive(32'h8765_4321, 32'h0000_0FE3, 4'b1101, "R3");
    // R6 signed compare at the overflow boundary.
    drive(32'h8000_0000, 32'h7FFF_FFFF, 4'b0010, "R6");
    drive(32'h7FFF_FFFF, 32'h8000_0000, 4'b0010, "R6");
    drive(32'hFFFF_FFFF, 32'h0000_0000, 4'b0010, "R6");
    drive(32'h0000_0004, 32'h0000_0004, 4'b0010, "R6");
    // R7 unsigned compare.
    drive(32'h8000_0000, 32'h7FFF_FFFF, 4'b0011, "R7");
    drive(32'h0000_0001, 32'hFFFF_FFFF, 4'b0011, "R7");
    drive(32'h0000_0009, 32'h0000_0009, 4'b0011, "R7");
    // R8 bitwise.
    drive(32'hF0F0_1234, 32'h0FF0_FF00, 4'b0100, "R8");
    drive(32'hF0F0_1234, 32'h0FF0_FF00, 4'b0110, "R8");
    drive(32'hF0F0_1234, 32'h0FF0_FF00, 4'b0111, "R8");
    // R9 every unused code.
    drive(32'h8000_0010, 32'h0000_0103, 4'b1001, "R9");
    drive(32'h8000_0010, 32'h0000_0103, 4'b1010, "R9");
    drive(32'h8000_0010, 32'h0000_0103, 4'b1011, "R9");
    drive(32'h8000_0010, 32'h0000_0103, 4'b1100, "R9");
    drive(32'h8000_0010, 32'h0000_0103, 4'b1110, "R9");
    drive(32'h8000_0010, 32'h0000_0103, 4'b1111, "R9");

    // R10: a new vector every cycle, so each result must follow its own inputs.
    s = 32'h1357_9BDF;
    for (int i = 0; i < 400; i++) begin
      logic [31:0] ra, rb;
      s ^= s << 13; s ^= s >> 17; s ^= s << 5;
      ra = s;
      s ^= s << 13; s ^= s >> 17; s ^= s << 5;
      rb = s;
      drive(ra, rb, 4'(i), $sformatf("R10/%s", tag_of(4'(i))));
    end

    @(posedge clk);
    @(posedge clk);
    done = 1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

endmodule